// File: doc/BRIEF.md
# Absolute Difference and Maximum Unit

This block takes pixel pairs of unsigned 8-bit grayscale data. One pixel of each pair comes from the frame now arriving and the other from a stored background picture. Every lane produces the magnitude of the gap between its two pixels. Four lanes work side by side, so each accepted beat yields four difference bytes. The results leave through a single registered stage that takes valid/ready flow control at both edges. The block is meant for change-detection front ends, where a later stage turns the differences into a binary image.

Alongside the difference stream, the block keeps a running maximum over one image tile of 80x60 pixels. At four pixels per beat, a tile is 1200 beats. A beat counter marks the final beat of each tile. When that beat enters the output register, the unit does three things on the same edge: it publishes the largest difference of the whole tile, it raises a one-cycle completion strobe, and it clears its running maximum for the next tile. The published maximum is the quantity a threshold stage needs, and it stays fixed until the next tile completes.

Top module: `absdiff_max_unit`

## Requirements
- R1: For every lane i, the output byte out_diff[8i+7:8i] equals |in_cur[8i+7:8i] - in_bkg[8i+7:8i]|, taken as unsigned 8-bit values.
- R2: in_ready is high whenever the output register is empty or out_ready is high. This lets the unit accept one four-lane beat on every clock edge while the downstream side keeps pace.
- R3: An accepted beat appears on out_diff with out_valid high after exactly one clock edge. While out_valid is high and out_ready is low, out_valid, out_diff and out_last hold their values.
- R4: out_last is high on every 1200th beat that is accepted since reset, and on no other beat.
- R5: max_done is a one-cycle pulse. It is raised on the same edge that loads the final beat of a tile into the output register. In that cycle max_val equals the largest difference byte over all 4800 pixels of the tile.
- R6: The running maximum starts from zero for every tile, so a tile's reported maximum never depends on pixels from earlier tiles.
- R7: max_val does not change except in a cycle where max_done is high.
- R8: After reset, out_valid, out_last, max_done and max_val are all zero and in_ready is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Unit can take a beat |
| in_cur | input | 32 | Four current-frame pixels, lane i in bits 8i+7:8i |
| in_bkg | input | 32 | Four background pixels, same lane order |
| out_valid | output | 1 | Difference beat valid |
| out_ready | input | 1 | Downstream takes the beat |
| out_diff | output | 32 | Four absolute differences, same lane order |
| out_last | output | 1 | Beat is the final one of a tile |
| max_val | output | 8 | Maximum difference of the last completed tile |
| max_done | output | 1 | One-cycle strobe: max_val was just updated |

## Verification
The difference bytes and out_last of a beat taken on a clock edge become visible right after that edge. max_done and the new max_val become visible right after the edge that takes a tile's final beat. The bench drives its inputs on the falling edge and decides acceptance 2 ns before the next rising edge, with in_ready already settled. It then queues the expected bytes and last flag. On each falling edge it first chooses out_ready and then compares the output beat that will transfer on the coming rising edge. A pending tile maximum is compared on the first falling edge after the accepting edge. On every other falling edge the bench checks that max_done is low and max_val unchanged.

// File: rtl/amu_pkg.sv
package amu_pkg;
  localparam int PIX_W_DEF       = 8;
  localparam int LANES_DEF       = 4;
  localparam int CHUNK_BEATS_DEF = 1200;

  function automatic logic [PIX_W_DEF-1:0] larger(input logic [PIX_W_DEF-1:0] a,
                                                   input logic [PIX_W_DEF-1:0] b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/amu_lane.sv
module amu_lane #(
  parameter int PIX_W = 8
) (
  input  logic [PIX_W-1:0] cur,
  input  logic [PIX_W-1:0] bkg,
  output logic [PIX_W-1:0] diff
);
  always_comb begin
    if (cur >= bkg) diff = cur - bkg;
    else            diff = bkg - cur;
  end
endmodule

// File: rtl/amu_max_reduce.sv
module amu_max_reduce #(
  parameter int PIX_W = 8,
  parameter int LANES = 4
) (
  input  logic [LANES-1:0][PIX_W-1:0] vals,
  output logic [PIX_W-1:0]            max_out
);
  logic [LANES-1:0][PIX_W-1:0] chain;

  assign chain[0] = vals[0];
  genvar g;
  generate
    for (g = 1; g < LANES; g++) begin : g_stage
      assign chain[g] = (vals[g] > chain[g-1]) ? vals[g] : chain[g-1];
    end
  endgenerate
  assign max_out = chain[LANES-1];
endmodule

// File: rtl/amu_beat_ctr.sv
module amu_beat_ctr #(
  parameter int CHUNK_BEATS = 1200
) (
  input  logic clk,
  input  logic rst,
  input  logic step,
  output logic is_last
);
  localparam int CW = (CHUNK_BEATS > 1) ? $clog2(CHUNK_BEATS) : 1;
  localparam logic [CW-1:0] LAST_IDX = CW'(CHUNK_BEATS - 1);

  logic [CW-1:0] cnt;

  assign is_last = (cnt == LAST_IDX);

  always_ff @(posedge clk) begin
    if (rst)          cnt <= '0;
    else if (step)    cnt <= is_last ? '0 : cnt + 1'b1;
  end

  assert_count_range_R4: assert property (@(posedge clk) disable iff (rst)
    cnt <= LAST_IDX);

  assert_wrap_after_last_R4: assert property (@(posedge clk) disable iff (rst)
    (step && is_last) |=> (cnt == '0));
endmodule

// File: rtl/absdiff_max_unit.sv
module absdiff_max_unit #(
  parameter int PIX_W       = amu_pkg::PIX_W_DEF,
  parameter int LANES       = amu_pkg::LANES_DEF,
  parameter int CHUNK_BEATS = amu_pkg::CHUNK_BEATS_DEF
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [LANES*PIX_W-1:0] in_cur,
  input  logic [LANES*PIX_W-1:0] in_bkg,
  output logic                   out_valid,
  input  logic                   out_ready,
  output logic [LANES*PIX_W-1:0] out_diff,
  output logic                   out_last,
  output logic [PIX_W-1:0]       max_val,
  output logic                   max_done
);
  localparam int BUS_W = LANES * PIX_W;

  logic [LANES-1:0][PIX_W-1:0] cur_v, bkg_v, diff_c, diff_q;
  logic [PIX_W-1:0]            beat_max, run_max, cand;
  logic                        accept, is_last;

  assign cur_v = in_cur;
  assign bkg_v = in_bkg;

  genvar l;
  generate
    for (l = 0; l < LANES; l++) begin : g_lane
      amu_lane #(.PIX_W(PIX_W)) i_lane (
        .cur (cur_v[l]),
        .bkg (bkg_v[l]),
        .diff(diff_c[l])
      );
    end
  endgenerate

  amu_max_reduce #(.PIX_W(PIX_W), .LANES(LANES)) i_reduce (
    .vals   (diff_c),
    .max_out(beat_max)
  );

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  amu_beat_ctr #(.CHUNK_BEATS(CHUNK_BEATS)) i_ctr (
    .clk    (clk),
    .rst    (rst),
    .step   (accept),
    .is_last(is_last)
  );

  assign cand = (beat_max > run_max) ? beat_max : run_max;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      diff_q    <= '0;
      out_last  <= 1'b0;
      run_max   <= '0;
      max_val   <= '0;
      max_done  <= 1'b0;
    end else begin
      max_done <= 1'b0;
      if (accept) begin
        out_valid <= 1'b1;
        diff_q    <= diff_c;
        out_last  <= is_last;
        if (is_last) begin
          run_max  <= '0;
          max_val  <= cand;
          max_done <= 1'b1;
        end else begin
          run_max  <= cand;
        end
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

  assign out_diff = BUS_W'(diff_q);

  assert_hold_under_stall_R3: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_diff) && $stable(out_last)));

  assert_done_on_last_R5: assert property (@(posedge clk) disable iff (rst)
    max_done |-> (out_valid && out_last));

  assert_done_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    max_done |=> !max_done);

  assert_max_stable_R7: assert property (@(posedge clk) disable iff (rst)
    !max_done |-> $stable(max_val));

  generate
    for (l = 0; l < LANES; l++) begin : g_chk
      assert_max_covers_lane_R5: assert property (@(posedge clk) disable iff (rst)
        max_done |-> (max_val >= diff_q[l]));
    end
  endgenerate
endmodule

// File: tb/test_absdiff_max_unit.sv
`timescale 1ns/1ps
module test_absdiff_max_unit;
  localparam int LANES = 4;
  localparam int PW    = 8;
  localparam int CB    = 1200;
  localparam int NCHUNK = 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_cur = '0, in_bkg = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [31:0] out_diff;
  logic        out_last;
  logic [7:0]  max_val;
  logic        max_done;

  int total = 0, bad = 0;
  bit finished = 0, started = 0;
  bit pend_done = 0;
  logic [7:0] exp_max = 8'd0, last_max = 8'd0;
  logic [31:0] q_diff[$];
  bit q_last[$];

  absdiff_max_unit i_absdiff_max_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_cur(in_cur), .in_bkg(in_bkg), .out_valid(out_valid), .out_ready(out_ready),
    .out_diff(out_diff), .out_last(out_last), .max_val(max_val), .max_done(max_done)
  );

  always #4 clk = ~clk;

  function automatic logic [31:0] ref_diff(input logic [31:0] c, input logic [31:0] b);
    logic [31:0] r;
    for (int i = 0; i < LANES; i++) begin
      logic [7:0] x, y;
      x = c[8*i +: 8];
      y = b[8*i +: 8];
      r[8*i +: 8] = (x > y) ? x - y : y - x;
    end
    return r;
  endfunction

  function automatic logic [7:0] ref_max(input logic [31:0] d);
    logic [7:0] m = 8'd0;
    for (int i = 0; i < LANES; i++) if (d[8*i +: 8] > m) m = d[8*i +: 8];
    return m;
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // driver
  initial begin
    int seed;
    int sent;
    logic [7:0] chunk_max;
    seed = 32'h5eed_1234;
    void'($urandom(seed));
    sent = 0;
    chunk_max = 8'd0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(out_valid == 1'b0 && out_last == 1'b0, "R8 out flags", {out_valid, out_last}, 0);
    check(max_done == 1'b0 && max_val == 8'd0, "R8 max", {max_done, max_val}, 0);
    check(in_ready == 1'b1, "R8 in_ready", in_ready, 1);
    started = 1;
    while (sent < NCHUNK * CB) begin
      int idx;
      @(negedge clk);
      idx = sent % CB;
      in_valid = ($urandom % 4) != 0;
      if (sent < 40) in_valid = 1'b1;
      if (sent / CB == 0) begin
        in_cur = $urandom;
        in_bkg = $urandom;
        if (idx == 5) begin in_cur = 32'hFF00_FF00; in_bkg = 32'h00FF_00FF; end
        if (idx == 6) begin in_cur = 32'h0000_0000; in_bkg = 32'hFFFF_FFFF; end
        if (idx == 7) begin in_cur = 32'h1234_5678; in_bkg = 32'h1234_5678; end
      end else begin
        in_cur = $urandom & 32'h3F3F_3F3F;
        in_bkg = $urandom & 32'h3F3F_3F3F;
      end
      #2;
      check(in_ready == (!out_valid || out_ready), "R2 in_ready", in_ready, (!out_valid || out_ready));
      if (in_valid && in_ready) begin
        logic [31:0] d;
        d = ref_diff(in_cur, in_bkg);
        q_diff.push_back(d);
        q_last.push_back(idx == CB - 1);
        if (ref_max(d) > chunk_max) chunk_max = ref_max(d);
        if (idx == CB - 1) begin
          exp_max = chunk_max;
          pend_done = 1;
          chunk_max = 8'd0;
        end
        sent++;
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
    while (q_diff.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    check(max_val == 8'd63 || max_val < 8'd64, "R6 chunk2 max below 64", max_val, 63);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  // monitor
  always @(negedge clk) begin
    if (started && !finished) begin
      out_ready = ($urandom % 10) < 7;
      if (out_valid && out_ready) begin
        if (q_diff.size() == 0) check(0, "R3 unexpected beat", out_diff, 0);
        else begin
          logic [31:0] ed;
          bit el;
          ed = q_diff.pop_front();
          el = q_last.pop_front();
          check(out_diff == ed, "R1 diff", out_diff, ed);
          check(out_last == el, "R4 last", out_last, el);
        end
      end
      if (pend_done) begin
        pend_done = 0;
        check(max_done == 1'b1, "R5 done", max_done, 1);
        check(max_val == exp_max, "R5 R6 max", max_val, exp_max);
        last_max = exp_max;
      end else begin
        check(max_done == 1'b0, "R5 stray done", max_done, 0);
        check(max_val == last_max, "R7 max held", max_val, last_max);
      end
    end
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule